// File: doc/BRIEF.md
# Borrow-Selected Maximum Register

This unit keeps the larger of two unsigned operands, `a_in` and `b_in`, in a result register. It has no magnitude comparator. An adder chain computes `a_in + ~b_in + 1` in WIDTH+1 bits. The inverted carry-out of that sum is the borrow, and the borrow is high exactly when `a_in < b_in`. The borrow drives the synchronous-load select in front of the result register. When it is high, the register takes `b_in` on its alternate load path. When it is low, the register takes `a_in` on its normal data path. The difference bits of the sum are never used.

The borrow is also driven out as a combinational less-than flag. A parent block can use it without adding a second comparator. The register updates only on enabled cycles and clears on a synchronous active-low reset.

Top module: `bsmax_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `max_q` becomes zero on that edge.
- R2: `a_lt_b` is combinational. It is 1 exactly when `a_in < b_in`, with both operands read as unsigned.
- R3: On an edge with `en` high and `a_in < b_in`, `max_q` loads `b_in`.
- R4: On an edge with `en` high and `a_in >= b_in`, `max_q` loads `a_in`.
- R5: Equal operands give `a_lt_b` = 0, and an enabled edge then loads `a_in`.
- R6: On an edge with `en` low and reset inactive, `max_q` keeps its value.
- R7: The result is correct at the range limits: zero against zero, all-ones against all-ones, and zero against all-ones in both orders.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Update enable for the result register |
| a_in | input | WIDTH | First unsigned operand |
| b_in | input | WIDTH | Second unsigned operand |
| max_q | output | WIDTH | Registered maximum of the operands |
| a_lt_b | output | 1 | Combinational borrow flag, 1 when a_in < b_in |

## Verification
A wrong carry-in or a wrong carry inversion in the chain shows up at once on `a_lt_b`, in the same cycle the operands are applied. The clearest cases are equal operands and operands that differ only in the low bit. A swapped load path or a wrong select polarity shows up in `max_q` one edge after an enabled cycle, as the smaller operand. A broken enable shows up as a change in `max_q` after an edge with `en` low.

// File: rtl/bsmax_pkg.sv
// Package bsmax_pkg
// Purpose: shared width parameter and the select encoding for the result register.
// Assumes: operands are unsigned.
package bsmax_pkg;
    localparam int unsigned DEF_WIDTH = 16;

    // Which path the result register loads on an enabled edge.
    typedef enum logic {
        SEL_DATA  = 1'b0,   // normal data input: operand a
        SEL_SLOAD = 1'b1    // synchronous-load input: operand b
    } load_sel_e;
endpackage

// File: rtl/bsmax_borrow_chain.sv
// Module bsmax_borrow_chain
// Purpose: forms a + ~b + 1 with a ripple of one-bit full adders and
//          returns the inverted top carry, which is the unsigned borrow (a < b).
// Assumes: unsigned operands. The sum bits are computed but left unused.
module bsmax_borrow_chain #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic             borrow
);
    // Carry node k feeds bit k; node WIDTH is the top carry.
    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] diff_unused;

    assign carry[0] = 1'b1;   // the +1 of the two's-complement subtraction

    for (genvar k = 0; k < WIDTH; k++) begin : g_cell
        logic nb;
        assign nb = ~op_b[k];
        // One full-adder cell of the chain.
        assign diff_unused[k] = op_a[k] ^ nb ^ carry[k];
        assign carry[k+1]     = (op_a[k] & nb) | (carry[k] & (op_a[k] ^ nb));
    end

    // No carry out of the top bit means a borrow, so a < b.
    assign borrow = ~carry[WIDTH];

    // Combinational self-check: the borrow must match an unsigned compare (R2).
    always_comb begin
        a_r2_borrow_matches: assert (borrow === (op_a < op_b) || $isunknown({op_a, op_b}))
            else $error("R2 borrow mismatch");
    end
endmodule

// File: rtl/bsmax_sload_reg.sv
// Module bsmax_sload_reg
// Purpose: a register bank with a synchronous-load input beside its normal
//          data input, a clock enable, and a synchronous active-low clear.
// Assumes: clear has priority over enable; sload only matters on enabled edges.
module bsmax_sload_reg
    import bsmax_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  load_sel_e        sel,
    input  logic [WIDTH-1:0] d_data,
    input  logic [WIDTH-1:0] d_sload,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] d_next;

    // Pick the input the register captures on this edge.
    always_comb begin
        d_next = (sel == SEL_SLOAD) ? d_sload : d_data;
    end

    // Clear on reset; otherwise load the chosen input when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (en)
            q <= d_next;
    end

    a_r1_clear: assert property (@(posedge clk) !rst_n |=> (q == '0))
        else $error("R1 clear failed");
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q)) else $error("R6 hold failed");
endmodule

// File: rtl/bsmax_top.sv
// Module bsmax_top
// Purpose: registered unsigned maximum. The borrow of a - b selects b on the
//          synchronous-load path; otherwise a takes the normal data path.
// Assumes: unsigned operands, single-cycle latency, synchronous active-low reset.
module bsmax_top
    import bsmax_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] max_q,
    output logic             a_lt_b
);
    logic      borrow;
    load_sel_e sel;

    bsmax_borrow_chain #(.WIDTH(WIDTH)) chain_i (
        .op_a  (a_in),
        .op_b  (b_in),
        .borrow(borrow)
    );

    // Turn the borrow into the register's load select.
    always_comb begin
        sel = borrow ? SEL_SLOAD : SEL_DATA;
    end

    bsmax_sload_reg #(.WIDTH(WIDTH)) reg_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .sel    (sel),
        .d_data (a_in),
        .d_sload(b_in),
        .q      (max_q)
    );

    assign a_lt_b = borrow;

    a_r3_loads_b: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (a_in < b_in)) |=> (max_q == $past(b_in))) else $error("R3 failed");
    a_r4_loads_a: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (a_in >= b_in)) |=> (max_q == $past(a_in))) else $error("R4 failed");
    a_r5_equal_low: assert property (@(posedge clk) disable iff (!rst_n)
        (a_in == b_in) |-> !a_lt_b) else $error("R5 failed");
endmodule

// File: tb/bsmax_top_tb_top.sv
module bsmax_top_tb_top;
    localparam int unsigned W = 16;
    localparam logic [W-1:0] ONES = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [W-1:0] max_q;
    logic a_lt_b;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        logic [W-1:0] val;
        string        tag;
    } exp_t;

    exp_t exp_q[$];

    always #10 clk = ~clk;   // 50 MHz

    bsmax_top #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en),
        .a_in(a_in), .b_in(b_in), .max_q(max_q), .a_lt_b(a_lt_b)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: apply operands on a falling edge, check the flag, and queue the expected result.
    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
        exp_t e;
        @(negedge clk);
        a_in = a;
        b_in = b;
        en = 1'b1;
        #1;
        check({tag, " R2 flag"}, {{(W-1){1'b0}}, a_lt_b}, {{(W-1){1'b0}}, (a < b)});
        e.val = (a < b) ? b : a;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare the registered result one edge after each enabled cycle.
    always @(posedge clk) begin
        if (rst_n && en) begin
            @(negedge clk);
            if (exp_q.size() != 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, max_q, e.val);
            end
        end
    end

    initial begin
        #4_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [W-1:0] hold_v;
        a_in = 16'h1234;
        b_in = 16'h5678;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", max_q, '0);
        rst_n = 1'b1;

        drive(16'h0003, 16'h0009, "R3 a<b");
        drive(16'h0900, 16'h0010, "R4 a>b");
        drive(16'h0042, 16'h0042, "R5 equal");
        drive(16'h0042, 16'h0043, "R3 lsb diff");
        drive(16'h8000, 16'h7FFF, "R4 msb");
        drive('0, '0, "R7 zeros");
        drive(ONES, ONES, "R7 ones");
        drive('0, ONES, "R7 zero vs ones");
        drive(ONES, '0, "R7 ones vs zero");

        for (int i = 0; i < 200; i++) begin
            logic [W-1:0] ra, rb;
            ra = W'($urandom);
            rb = (i % 7 == 0) ? ra : W'($urandom);
            drive(ra, rb, (ra < rb) ? "R3 random" : "R4 random");
        end

        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        hold_v = max_q;
        a_in = 16'hFFFE;
        b_in = 16'h0001;
        repeat (3) @(negedge clk);
        check("R6 hold", max_q, hold_v);

        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset again", max_q, '0);

        check("R3 queue drained", W'(exp_q.size()), '0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule